// File: doc/BRIEF.md
# Segmented Address Translator with Context Selection

This block turns a 21-bit logical byte address into a 19-bit physical byte address in two lookups. The upper six address bits pick an entry in a segment register file that is kept per context. That entry names one of 64 page segments and carries a 2-bit access code. The page segment number, joined with the next four address bits, indexes a shared page file. The 8-bit page value found there, joined with the 11-bit offset, forms the physical address.

The source of the access chooses the context. A DMA access always uses context 0. A processor access in supervisor state uses context 1. A user access uses a programmable 4-bit context register that can never hold 0 or 1. Accesses the access code forbids, and accesses that reach the reserved all-ones page value, raise a bus-error strobe in place of a valid address. The first such fault is latched with its cause and its logical address until software clears it.

A small register port lets software write and read back both files, the context register and the fault cause.

Top module: `mmu_xlate`

## Requirements
- R1: One cycle after `acc_req` is sampled high for a permitted access to a valid page, `phys_valid` is 1 and `phys_addr` = {page value, `acc_addr[10:0]`}. The segment register is indexed by `acc_addr[20:15]`, and the page entry is indexed by {segment entry bits 5:0, `acc_addr[14:11]`}. In every other cycle `phys_addr` is 0.
- R2: The context is 0 when `acc_dma` is 1, whatever `acc_super` is. It is 1 when only `acc_super` is 1. Otherwise it is the context register.
- R3: Segment entry bits 7:6 give the access code. Code 0 allows nothing, code 1 allows read only, code 2 allows everything, and code 3 allows fetch only. `acc_kind` is 0 for read, 1 for write and 2 for fetch, and 3 is treated as a read. A forbidden access gives `bus_err`=1 and `phys_valid`=0 one cycle later.
- R4: A permitted access whose page entry is 0xFF gives `bus_err`=1 and `phys_valid`=0 one cycle later.
- R5: On a fault while no cause is pending, `exc_cause` becomes 1 for an access-code fault or 2 for an invalid page, and `exc_addr` takes the logical address. An access-code fault takes precedence over an invalid page. Later faults leave both outputs unchanged.
- R6: A register write of 0 to the fault register clears `exc_cause` and `exc_addr`. A non-zero write has no effect.
- R7: The context register resets to 2. A write of 0 or 1 stores 2, and any other value is stored as written.
- R8: The register port uses `cfg_sel` 0 for the segment file (`cfg_addr` = {context, segment}), 1 for the page file (`cfg_addr` = {page segment, page}), 2 for the context register and 3 for the fault cause. `cfg_rdata` returns the selected value, zero-extended, one cycle after `cfg_sel`/`cfg_addr` are presented.
- R9: A register write changes the translation of an access sampled on the very next clock edge.
- R10: After reset, `phys_valid`, `bus_err` and `exc_cause` are 0.
- R11: A cycle with `acc_req` low gives `phys_valid`=0 and `bus_err`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Access request |
| acc_addr | input | 21 | Logical byte address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_super | input | 1 | Processor in supervisor state |
| acc_dma | input | 1 | Access comes from DMA |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register target select |
| cfg_addr | input | 10 | Entry index in the selected file |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read-back data |
| phys_valid | output | 1 | Translated address is valid |
| phys_addr | output | 19 | Physical byte address |
| bus_err | output | 1 | Access faulted |
| exc_cause | output | 2 | Latched fault cause |
| exc_addr | output | 21 | Logical address of the latched fault |

## Verification
The hardest situations to reach are the combined ones. One is a segment whose access code forbids the access while its page entry also holds 0xFF. The other is a second fault arriving while the first is still latched. Reaching them needs both files loaded deliberately. The bench fills every segment and page entry with arithmetic patterns that cover all four access codes and include natural 0xFF values. It sweeps every segment under every context source and access kind, and then overwrites chosen page entries to build the overlapping faults in sequence. A page write followed immediately by an access to that page shows whether the new value is used on the next edge.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    PROT_DENY  = 2'd0,
    PROT_RDONY = 2'd1,
    PROT_FULL  = 2'd2,
    PROT_XONLY = 2'd3
  } prot_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_PROT  = 2'd1,
    CAUSE_INVPG = 2'd2
  } cause_e;

  typedef enum logic [1:0] {
    SEL_SEG  = 2'd0,
    SEL_PAGE = 2'd1,
    SEL_CTX  = 2'd2,
    SEL_EXC  = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/mmu_lut_ram.sv
module mmu_lut_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/mmu_ctx_sel.sv
module mmu_ctx_sel #(
  parameter int CTX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTX_W-1:0] wr_val,
  input  logic             acc_dma,
  input  logic             acc_super,
  output logic [CTX_W-1:0] ctx_q,
  output logic [CTX_W-1:0] act_ctx
);
  localparam logic [CTX_W-1:0] CTX_DMA     = CTX_W'(0);
  localparam logic [CTX_W-1:0] CTX_SUP     = CTX_W'(1);
  localparam logic [CTX_W-1:0] CTX_USR_MIN = CTX_W'(2);

  logic [CTX_W-1:0] ctx_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_r <= CTX_USR_MIN;
    end else if (wr_en) begin
      ctx_r <= (wr_val < CTX_USR_MIN) ? CTX_USR_MIN : wr_val;
    end
  end

  always_comb begin
    if (acc_dma)        act_ctx = CTX_DMA;
    else if (acc_super) act_ctx = CTX_SUP;
    else                act_ctx = ctx_r;
  end

  assign ctx_q = ctx_r;

  // R7: user context register never reaches the DMA or supervisor slots
  a_r7_ctx_floor: assert property (@(posedge clk) disable iff (rst)
    ctx_r >= CTX_USR_MIN);

  // R7: a write of a reserved value lands on the lowest user context
  a_r7_low_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_val < CTX_USR_MIN) |=> ctx_r == CTX_USR_MIN);
endmodule

// File: rtl/mmu_prot_chk.sv
module mmu_prot_chk (
  input  logic [1:0] code,
  input  logic [1:0] kind,
  output logic       allow
);
  import mmu_pkg::*;

  prot_e     code_e;
  acc_kind_e kind_e;

  assign code_e = prot_e'(code);
  assign kind_e = acc_kind_e'(kind);

  always_comb begin
    allow = 1'b0;
    unique case (code_e)
      PROT_DENY:  allow = 1'b0;
      PROT_RDONY: allow = (kind_e == ACC_READ) || (kind_e == ACC_RSVD);
      PROT_FULL:  allow = 1'b1;
      PROT_XONLY: allow = (kind_e == ACC_FETCH);
      default:    allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate #(
  parameter int CTX_W = 4,
  parameter int SEG_W = 6,
  parameter int PG_W  = 4,
  parameter int OFF_W = 11,
  parameter int PPN_W = 8,
  localparam int LA_W   = SEG_W + PG_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int SEGE_W = SEG_W + 2,
  localparam int SF_AW  = CTX_W + SEG_W,
  localparam int PF_AW  = SEG_W + PG_W,
  localparam int CFG_AW = (SF_AW > PF_AW) ? SF_AW : PF_AW,
  localparam int DW     = (SEGE_W > PPN_W) ? SEGE_W : PPN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_req,
  input  logic [LA_W-1:0]   acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_super,
  input  logic              acc_dma,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              phys_valid,
  output logic [PA_W-1:0]   phys_addr,
  output logic              bus_err,
  output logic [1:0]        exc_cause,
  output logic [LA_W-1:0]   exc_addr
);
  import mmu_pkg::*;

  localparam logic [PPN_W-1:0] PPN_INVALID = '1;

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  // address fields
  logic [SEG_W-1:0] seg_idx;
  logic [PG_W-1:0]  pg_idx;
  logic [OFF_W-1:0] off;
  assign seg_idx = acc_addr[LA_W-1 -: SEG_W];
  assign pg_idx  = acc_addr[OFF_W +: PG_W];
  assign off     = acc_addr[OFF_W-1:0];

  // context selection
  logic [CTX_W-1:0] ctx_q, act_ctx;
  logic             ctx_wr;
  assign ctx_wr = cfg_we && (sel == SEL_CTX);

  mmu_ctx_sel #(.CTX_W(CTX_W)) u_ctx (
    .clk(clk), .rst(rst),
    .wr_en(ctx_wr), .wr_val(cfg_wdata[CTX_W-1:0]),
    .acc_dma(acc_dma), .acc_super(acc_super),
    .ctx_q(ctx_q), .act_ctx(act_ctx)
  );

  // segment file, one bank per context
  logic              seg_we;
  logic [SEGE_W-1:0] seg_ent, seg_rb;
  assign seg_we = cfg_we && (sel == SEL_SEG);

  mmu_lut_ram #(.AW(SF_AW), .DW(SEGE_W)) u_segf (
    .clk(clk), .we(seg_we),
    .waddr(cfg_addr[SF_AW-1:0]), .wdata(cfg_wdata[SEGE_W-1:0]),
    .raddr_a({act_ctx, seg_idx}), .rdata_a(seg_ent),
    .raddr_b(cfg_addr[SF_AW-1:0]), .rdata_b(seg_rb)
  );

  logic [SEG_W-1:0] pseg;
  logic [1:0]       prot_code;
  assign pseg      = seg_ent[SEG_W-1:0];
  assign prot_code = seg_ent[SEGE_W-1 -: 2];

  // shared page file
  logic             pg_we;
  logic [PPN_W-1:0] ppn, pg_rb;
  assign pg_we = cfg_we && (sel == SEL_PAGE);

  mmu_lut_ram #(.AW(PF_AW), .DW(PPN_W)) u_pagef (
    .clk(clk), .we(pg_we),
    .waddr(cfg_addr[PF_AW-1:0]), .wdata(cfg_wdata[PPN_W-1:0]),
    .raddr_a({pseg, pg_idx}), .rdata_a(ppn),
    .raddr_b(cfg_addr[PF_AW-1:0]), .rdata_b(pg_rb)
  );

  // access check
  logic allow;
  mmu_prot_chk u_prot (
    .code(prot_code), .kind(acc_kind), .allow(allow)
  );

  logic prot_fault, inv_fault, acc_ok, any_fault;
  assign prot_fault = acc_req && !allow;
  assign inv_fault  = acc_req && allow && (ppn == PPN_INVALID);
  assign acc_ok     = acc_req && allow && (ppn != PPN_INVALID);
  assign any_fault  = prot_fault || inv_fault;

  // result register
  always_ff @(posedge clk) begin
    if (rst) begin
      phys_valid <= 1'b0;
      phys_addr  <= '0;
      bus_err    <= 1'b0;
    end else begin
      phys_valid <= acc_ok;
      phys_addr  <= acc_ok ? {ppn, off} : '0;
      bus_err    <= any_fault;
    end
  end

  // fault latch
  logic exc_clr;
  assign exc_clr = cfg_we && (sel == SEL_EXC) && (cfg_wdata == '0);

  cause_e cause_r;
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_r  <= CAUSE_NONE;
      exc_addr <= '0;
    end else begin
      if (exc_clr) begin
        cause_r  <= CAUSE_NONE;
        exc_addr <= '0;
      end
      if (any_fault && (cause_r == CAUSE_NONE || exc_clr)) begin
        cause_r  <= prot_fault ? CAUSE_PROT : CAUSE_INVPG;
        exc_addr <= acc_addr;
      end
    end
  end
  assign exc_cause = cause_r;

  // read-back
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      unique case (sel)
        SEL_SEG:  cfg_rdata <= DW'(seg_rb);
        SEL_PAGE: cfg_rdata <= DW'(pg_rb);
        SEL_CTX:  cfg_rdata <= DW'(ctx_q);
        SEL_EXC:  cfg_rdata <= DW'(cause_r);
        default:  cfg_rdata <= '0;
      endcase
    end
  end

  // R1, R3, R4: a cycle never shows both a valid address and a fault
  a_r1_excl: assert property (@(posedge clk) disable iff (rst)
    !(phys_valid && bus_err));

  // R11: no request, no strobe
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !acc_req |=> (!phys_valid && !bus_err));

  // R5: a bus error always leaves a cause behind
  a_r5_err_cause: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> exc_cause != 2'd0);

  // R5: a pending cause and its address hold until cleared
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (exc_cause != 2'd0 && !exc_clr) |=> ($stable(exc_cause) && $stable(exc_addr)));

  // R5: only two cause codes exist
  a_r5_legal: assert property (@(posedge clk) disable iff (rst)
    exc_cause != 2'd3);

  // R6: a clear with no fault in the same cycle empties the latch
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (exc_clr && !any_fault) |=> exc_cause == 2'd0);
endmodule

// File: tb/mmu_xlate_bench.sv
module mmu_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_req = 1'b0;
  logic [20:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_super = 1'b0;
  logic        acc_dma = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [9:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        phys_valid;
  logic [18:0] phys_addr;
  logic        bus_err;
  logic [1:0]  exc_cause;
  logic [20:0] exc_addr;

  int total = 0;
  int bad = 0;
  logic [7:0] seg_sh [1024];
  logic [7:0] pg_sh  [1024];
  int ctx_sh = 2;

  always #4 clk = ~clk;

  mmu_xlate u_mmu_xlate (
    .clk(clk), .rst(rst),
    .acc_req(acc_req), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .acc_super(acc_super), .acc_dma(acc_dma),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .phys_valid(phys_valid), .phys_addr(phys_addr), .bus_err(bus_err),
    .exc_cause(exc_cause), .exc_addr(exc_addr)
  );

  function automatic logic [7:0] seg_pat(int c, int s);
    return 8'((((s + c) % 4) << 6) | ((s * 5 + c * 3) % 64));
  endfunction

  function automatic logic [7:0] pg_pat(int i);
    return 8'((i * 29 + i / 16) % 256);
  endfunction

  function automatic bit permits(int code, int kind);
    case (code)
      0: return 1'b0;
      1: return (kind == 0) || (kind == 3);
      2: return 1'b1;
      default: return kind == 2;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(int sel, int addr, int data);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_addr = 10'(addr); cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 0) seg_sh[addr] = 8'(data);
    if (sel == 1) pg_sh[addr] = 8'(data);
    if (sel == 2) ctx_sh = (data < 2) ? 2 : data;
  endtask

  task automatic cfg_rd(int sel, int addr, output logic [7:0] val);
    cfg_sel = 2'(sel); cfg_addr = 10'(addr);
    @(negedge clk);
    val = cfg_rdata;
  endtask

  // one access, checked against the shadow model
  task automatic xlate(int s, int pg, int off, int kind, bit sup, bit dma, string tag);
    int c, code, ps, ppn;
    logic [7:0] se;
    bit e_ok, e_err;
    longint e_pa;
    c = dma ? 0 : (sup ? 1 : ctx_sh);
    se = seg_sh[c * 64 + s];
    code = int'(se[7:6]);
    ps = int'(se[5:0]);
    ppn = int'(pg_sh[ps * 16 + pg]);
    e_ok = permits(code, kind) && (ppn != 255);
    e_err = !e_ok;
    e_pa = e_ok ? longint'(ppn * 2048 + off) : 0;
    acc_req = 1'b1; acc_addr = 21'((s << 15) | (pg << 11) | off);
    acc_kind = 2'(kind); acc_super = sup; acc_dma = dma;
    @(negedge clk);
    acc_req = 1'b0;
    chk(phys_valid == e_ok && bus_err == e_err && phys_addr == 19'(e_pa), tag,
        {phys_valid, bus_err, phys_addr}, {e_ok, e_err, 19'(e_pa)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired, run incomplete (R1)");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    int ps_seg3, ps_seg1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state, R7 reset context
    chk(!phys_valid && !bus_err, "R10 strobes after reset", {phys_valid, bus_err}, 0);
    chk(exc_cause == 0, "R10 cause after reset", exc_cause, 0);
    cfg_rd(2, 0, rv);
    chk(rv == 8'd2, "R7 context reset value", rv, 2);

    // fill both files
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 64; s++) cfg_wr(0, c * 64 + s, seg_pat(c, s));
    for (int i = 0; i < 1024; i++) cfg_wr(1, i, pg_pat(i));

    // R8 read back every entry
    for (int i = 0; i < 1024; i++) begin
      cfg_rd(0, i, rv);
      chk(rv == seg_sh[i], "R8 segment read-back", rv, seg_sh[i]);
    end
    for (int i = 0; i < 1024; i++) begin
      cfg_rd(1, i, rv);
      chk(rv == pg_sh[i], "R8 page read-back", rv, pg_sh[i]);
    end

    // R1 R2 R3 R4 sweep: mode 0 DMA with supervisor also set, 1 supervisor, 2..15 user
    for (int m = 0; m < 16; m++) begin
      if (m >= 2) cfg_wr(2, m, m);
      for (int s = 0; s < 64; s++)
        for (int k = 0; k < 4; k++)
          xlate(s, (s + k) % 16, (s * 37 + k * 11) % 2048, k, m <= 1, m == 0,
                "R1 R2 R3 R4 translation sweep");
    end

    // R11 idle cycles
    @(negedge clk);
    chk(!phys_valid && !bus_err, "R11 idle strobes", {phys_valid, bus_err}, 0);

    // R6 clear
    cfg_wr(3, 0, 0);
    chk(exc_cause == 0 && exc_addr == 0, "R6 clear", exc_cause, 0);

    // R5 access-code fault wins over an invalid page: supervisor seg 3 has code 0
    ps_seg3 = int'(seg_sh[1 * 64 + 3][5:0]);
    cfg_wr(1, ps_seg3 * 16 + 2, 8'hFF);
    xlate(3, 2, 16, 0, 1'b1, 1'b0, "R3 fault on denied segment");
    chk(exc_cause == 1, "R5 cause code 1 over invalid page", exc_cause, 1);
    chk(exc_addr == 21'((3 << 15) | (2 << 11) | 16), "R5 fault address",
        exc_addr, (3 << 15) | (2 << 11) | 16);

    // R5 second fault ignored: supervisor seg 1 has code 2
    ps_seg1 = int'(seg_sh[1 * 64 + 1][5:0]);
    cfg_wr(1, ps_seg1 * 16 + 5, 8'hFF);
    xlate(1, 5, 7, 1, 1'b1, 1'b0, "R4 invalid page fault");
    chk(exc_cause == 1 && exc_addr == 21'((3 << 15) | (2 << 11) | 16),
        "R5 latch holds first fault", exc_cause, 1);

    // R6 non-zero write ignored, zero write clears
    cfg_wr(3, 0, 5);
    cfg_rd(3, 0, rv);
    chk(rv == 8'd1, "R6 non-zero write no effect", rv, 1);
    cfg_wr(3, 0, 0);
    cfg_rd(3, 0, rv);
    chk(rv == 8'd0, "R6 zero write clears", rv, 0);

    // R5 invalid page cause
    xlate(1, 5, 7, 0, 1'b1, 1'b0, "R4 invalid page read");
    chk(exc_cause == 2, "R5 cause code 2", exc_cause, 2);
    chk(exc_addr == 21'((1 << 15) | (5 << 11) | 7), "R5 invalid page address",
        exc_addr, (1 << 15) | (5 << 11) | 7);
    cfg_wr(3, 0, 0);

    // R9 write then access on the next edge
    cfg_wr(1, ps_seg1 * 16 + 5, 8'h42);
    xlate(1, 5, 7, 0, 1'b1, 1'b0, "R9 page write seen next cycle");
    chk(phys_addr == 19'((8'h42 << 11) | 7) || !phys_valid, "R9 new page value",
        phys_addr, (8'h42 << 11) | 7);

    // R7 reserved context writes
    cfg_wr(2, 0, 0);
    cfg_rd(2, 0, rv);
    chk(rv == 8'd2, "R7 write 0 stores 2", rv, 2);
    for (int s = 0; s < 64; s++) xlate(s, 3, 100, 2, 1'b0, 1'b0, "R7 R2 user uses context 2");
    cfg_wr(2, 0, 1);
    cfg_rd(2, 0, rv);
    chk(rv == 8'd2, "R7 write 1 stores 2", rv, 2);
    cfg_wr(2, 0, 15);
    cfg_rd(2, 0, rv);
    chk(rv == 8'd15, "R7 write 15 stored", rv, 15);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule